// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Loader

This block stores the two programmable threshold offsets that a deep FIFO compares against its fill level: one for the almost-empty flag and one for the almost-full flag. Each offset is `OFS_W` bits wide (17 or 18 in practice). It is kept as a 16-bit low word and a short high word of `OFS_W-16` bits. That gives four addressable words. In order they are: empty low, empty high, full low, full high.

While the asynchronous reset is held, the configuration-select input `cfg_sel` sets two things. It picks the low-word defaults, and it picks the loading method. The loading method is either word-parallel over `din` or bit-serial through `din[0]`. That choice holds until the next reset. During operation, a low `cfg_sel` places the control strobes in offset-programming space. A high `cfg_sel` places them in FIFO-memory space, where they become the decoded strobes `mem_wr` and `mem_rd` for the surrounding FIFO. Writes and shifts are taken on `wclk`. Readback is produced on `rclk`.

Both clock domains release their reset through a two-flop synchronizer. The programming inputs are quasi-static relative to `rclk` reads.

Top module: `ofs_loader`

## Requirements
- R1: While reset is held, both low words load 0x007F when `cfg_sel` is 0, or 0x03FF when `cfg_sel` is 1. Both high words load 0.
- R2: Reset with `cfg_sel`=0 selects the parallel method. Reset with `cfg_sel`=1 selects the serial method. Toggling `cfg_sel` after reset release does not change the method.
- R3: A parallel write (`cfg_sel`=0, `wr_en_n`=0, `rd_en_n`=1, `shift_en_n`=1, parallel method) stores into the word at the write pointer on a `wclk` edge. The pointer then advances in the order empty low, empty high, full low, full high, and wraps to empty low. A low word takes `din[15:0]`. A high word takes only `din[OFS_W-17:0]`; the upper `din` bits are dropped.
- R4: A parallel read (`cfg_sel`=0, `wr_en_n`=1, `rd_en_n`=0) updates `dout` on the next `rclk` edge. It returns the word at the read pointer, zero-extended, and the pointer advances in the same wrapping order as R3. Reads work under either method. `dout` holds its value when no read is decoded.
- R5: A serial shift (`cfg_sel`=0, `wr_en_n`=1, `rd_en_n`=1, `shift_en_n`=0, serial method) stores `din[0]` into one bit per `wclk` edge. Bit k of the 2·`OFS_W`-bit vector {full, empty} is written on the k-th shift. The first bit is bit 0 of the empty offset and the last is the top bit of the full offset.
- R6: After 2·`OFS_W` shifts the bit counter returns to 0, so a further shift rewrites bit 0 of the empty offset.
- R7: A parallel write under the serial method, and a serial shift under the parallel method, leave both offsets unchanged.
- R8: With `cfg_sel`=1, `mem_wr` equals NOT `wr_en_n` and `mem_rd` equals NOT `rd_en_n`, combinationally. No offset word is written and `dout` does not change. With `cfg_sel`=0 both strobes are 0.
- R9: Reset clears the write pointer, the read pointer and the serial bit counter. After reset, the first write, read or shift addresses empty low / bit 0.
- R10: Control combinations outside the decode of R3–R5 have no effect on the offsets. Examples are `wr_en_n`=0 with `rd_en_n`=0, and `wr_en_n`=0 with `shift_en_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock: parallel writes and serial shifts |
| rclk | input | 1 | Read-side clock: parallel readback |
| arst_n | input | 1 | Asynchronous active-low master reset |
| cfg_sel | input | 1 | Default/method select during reset; programming (0) or memory (1) space afterwards |
| wr_en_n | input | 1 | Active-low write strobe |
| rd_en_n | input | 1 | Active-low read strobe |
| shift_en_n | input | 1 | Active-low serial shift strobe |
| din | input | DATA_W | Parallel write data; bit 0 is the serial input |
| dout | output | DATA_W | Readback of the offset word at the read pointer |
| empty_ofs | output | OFS_W | Almost-empty offset |
| full_ofs | output | OFS_W | Almost-full offset |
| mem_wr | output | 1 | Decoded FIFO memory write strobe |
| mem_rd | output | 1 | Decoded FIFO memory read strobe |

## Verification
A write pointer that is off by one puts data into the wrong word. This shows on `empty_ofs`/`full_ofs` one `wclk` edge after the write, and it stays wrong for the rest of the sequence. A slipped read pointer or a stale `dout` shows at the next readback, because each read is scored against a model of the four words. A serial counter that wraps early or late, or a method latch that follows `cfg_sel` after reset, places a shifted bit in the wrong place or lets an ignored command through. Both show on the offset outputs as soon as the load finishes, or one edge after the stray command.

// File: rtl/ofs_pkg.sv
`timescale 1ns/1ps
package ofs_pkg;
  localparam int LSB_W = 16;
  localparam logic [LSB_W-1:0] DEF_LOW_SEL0 = 16'h007F;
  localparam logic [LSB_W-1:0] DEF_LOW_SEL1 = 16'h03FF;

  typedef enum logic {
    MODE_PAR = 1'b0,
    MODE_SER = 1'b1
  } load_mode_e;
endpackage

// File: rtl/ofs_rst_sync.sv
`timescale 1ns/1ps
module ofs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/ofs_cmd_decode.sv
`timescale 1ns/1ps
module ofs_cmd_decode (
  input  logic cfg_sel,
  input  logic wr_en_n,
  input  logic rd_en_n,
  input  logic shift_en_n,
  output logic par_wr,
  output logic par_rd,
  output logic ser_sh,
  output logic mem_wr,
  output logic mem_rd
);
  always_comb begin
    par_wr = 1'b0;
    par_rd = 1'b0;
    ser_sh = 1'b0;
    mem_wr = 1'b0;
    mem_rd = 1'b0;
    if (cfg_sel) begin
      mem_wr = !wr_en_n;
      mem_rd = !rd_en_n;
    end else begin
      par_wr = !wr_en_n && rd_en_n && shift_en_n;
      par_rd = wr_en_n && !rd_en_n;
      ser_sh = wr_en_n && rd_en_n && !shift_en_n;
    end
  end
endmodule

// File: rtl/ofs_wr_side.sv
`timescale 1ns/1ps
module ofs_wr_side
  import ofs_pkg::*;
#(
  parameter int OFS_W  = 18,
  parameter int DATA_W = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_sel,
  input  logic                 par_wr,
  input  logic                 ser_sh,
  input  logic [DATA_W-1:0]    din,
  output logic [2*OFS_W-1:0]   ofs_o,
  output load_mode_e           mode_o,
  output logic [$clog2(2*OFS_W)-1:0] cnt_o
);
  localparam int MSB_W = OFS_W - LSB_W;
  localparam int TOT_W = 2 * OFS_W;
  localparam int CNT_W = $clog2(TOT_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TOT_W - 1);

  logic [1:0]       wptr_q, wptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TOT_W-1:0] ofs_q, ofs_d;
  load_mode_e       mode_q, mode_d;
  logic [LSB_W-1:0] def_low;

  assign def_low = cfg_sel ? DEF_LOW_SEL1 : DEF_LOW_SEL0;

  always_comb begin
    wptr_d = wptr_q;
    cnt_d  = cnt_q;
    ofs_d  = ofs_q;
    mode_d = mode_q;
    if (!rst_n) begin
      mode_d = cfg_sel ? MODE_SER : MODE_PAR;
      ofs_d  = {{MSB_W{1'b0}}, def_low, {MSB_W{1'b0}}, def_low};
    end else if (par_wr && mode_q == MODE_PAR) begin
      case (wptr_q)
        2'd0: ofs_d[LSB_W-1:0]             = din[LSB_W-1:0];
        2'd1: ofs_d[OFS_W-1:LSB_W]         = din[MSB_W-1:0];
        2'd2: ofs_d[OFS_W+LSB_W-1:OFS_W]   = din[LSB_W-1:0];
        default: ofs_d[TOT_W-1:OFS_W+LSB_W] = din[MSB_W-1:0];
      endcase
      wptr_d = wptr_q + 2'd1;
    end else if (ser_sh && mode_q == MODE_SER) begin
      ofs_d[cnt_q] = din[0];
      cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    ofs_q  <= ofs_d;
    mode_q <= mode_d;
  end

  assign ofs_o  = ofs_q;
  assign mode_o = mode_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/ofs_rd_side.sv
`timescale 1ns/1ps
module ofs_rd_side
  import ofs_pkg::*;
#(
  parameter int OFS_W  = 18,
  parameter int DATA_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               par_rd,
  input  logic [2*OFS_W-1:0] ofs_i,
  output logic [DATA_W-1:0]  dout
);
  localparam int MSB_W = OFS_W - LSB_W;

  logic [DATA_W-1:0] slot [4];
  logic [1:0]        rptr_q, rptr_d;
  logic [DATA_W-1:0] dout_q, dout_d;

  for (genvar g = 0; g < 2; g++) begin : g_slot
    assign slot[2*g]   = DATA_W'(ofs_i[g*OFS_W +: LSB_W]);
    assign slot[2*g+1] = DATA_W'(ofs_i[g*OFS_W+LSB_W +: MSB_W]);
  end

  always_comb begin
    rptr_d = rptr_q;
    dout_d = dout_q;
    if (par_rd) begin
      dout_d = slot[rptr_q];
      rptr_d = rptr_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      dout_q <= '0;
    end else begin
      rptr_q <= rptr_d;
      dout_q <= dout_d;
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/ofs_loader.sv
`timescale 1ns/1ps
module ofs_loader
  import ofs_pkg::*;
#(
  parameter int OFS_W  = 18,
  parameter int DATA_W = 18
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              arst_n,
  input  logic              cfg_sel,
  input  logic              wr_en_n,
  input  logic              rd_en_n,
  input  logic              shift_en_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs,
  output logic              mem_wr,
  output logic              mem_rd
);
  localparam int TOT_W = 2 * OFS_W;
  localparam int CNT_W = $clog2(TOT_W);

  logic             w_rst_n, r_rst_n;
  logic             par_wr, par_rd, ser_sh;
  logic [TOT_W-1:0] ofs_all;
  load_mode_e       load_mode;
  logic [CNT_W-1:0] ser_cnt;

  ofs_rst_sync #(.STAGES(2)) u_wsync (.clk(wclk), .arst_n(arst_n), .rst_n_o(w_rst_n));
  ofs_rst_sync #(.STAGES(2)) u_rsync (.clk(rclk), .arst_n(arst_n), .rst_n_o(r_rst_n));

  ofs_cmd_decode u_dec (
    .cfg_sel(cfg_sel), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .shift_en_n(shift_en_n),
    .par_wr(par_wr), .par_rd(par_rd), .ser_sh(ser_sh), .mem_wr(mem_wr), .mem_rd(mem_rd)
  );

  ofs_wr_side #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_wr (
    .clk(wclk), .rst_n(w_rst_n), .cfg_sel(cfg_sel), .par_wr(par_wr), .ser_sh(ser_sh),
    .din(din), .ofs_o(ofs_all), .mode_o(load_mode), .cnt_o(ser_cnt)
  );

  ofs_rd_side #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rd (
    .clk(rclk), .rst_n(r_rst_n), .par_rd(par_rd), .ofs_i(ofs_all), .dout(dout)
  );

  assign empty_ofs = ofs_all[OFS_W-1:0];
  assign full_ofs  = ofs_all[TOT_W-1:OFS_W];
endmodule

// File: rtl/ofs_loader_chk.sv
`timescale 1ns/1ps
module ofs_loader_chk
  import ofs_pkg::*;
#(
  parameter int OFS_W  = 18,
  parameter int DATA_W = 18
) (
  input logic              wclk,
  input logic              rclk,
  input logic              arst_n,
  input logic              w_rst_n,
  input logic              r_rst_n,
  input logic              cfg_sel,
  input logic              wr_en_n,
  input logic              rd_en_n,
  input logic              shift_en_n,
  input logic [DATA_W-1:0] dout,
  input logic [OFS_W-1:0]  empty_ofs,
  input logic [OFS_W-1:0]  full_ofs,
  input logic              mem_wr,
  input logic              mem_rd,
  input load_mode_e        load_mode,
  input logic [$clog2(2*OFS_W)-1:0] ser_cnt
);
  localparam int TOT_W = 2 * OFS_W;

  assert_defaults_R1: assert property (@(posedge wclk) disable iff (!arst_n)
    $rose(w_rst_n) |-> (empty_ofs[OFS_W-1:LSB_W] == '0 && full_ofs[OFS_W-1:LSB_W] == '0 &&
      empty_ofs[LSB_W-1:0] == (load_mode == MODE_SER ? DEF_LOW_SEL1 : DEF_LOW_SEL0) &&
      full_ofs[LSB_W-1:0] == empty_ofs[LSB_W-1:0]));

  assert_mode_locked_R2: assert property (@(posedge wclk) disable iff (!arst_n)
    w_rst_n |=> $stable(load_mode));

  assert_no_strobe_prog_R8: assert property (@(posedge wclk) disable iff (!arst_n)
    !cfg_sel |-> (!mem_wr && !mem_rd));

  assert_hold_mem_space_R8: assert property (@(posedge wclk) disable iff (!arst_n)
    (w_rst_n && cfg_sel) |=> $stable({full_ofs, empty_ofs}));

  assert_shift_ignored_R7: assert property (@(posedge wclk) disable iff (!arst_n)
    (w_rst_n && load_mode == MODE_PAR && !cfg_sel && wr_en_n && rd_en_n && !shift_en_n)
      |=> $stable({full_ofs, empty_ofs}));

  assert_pwrite_ignored_R7: assert property (@(posedge wclk) disable iff (!arst_n)
    (w_rst_n && load_mode == MODE_SER && !cfg_sel && !wr_en_n)
      |=> $stable({full_ofs, empty_ofs}));

  assert_illegal_combo_R10: assert property (@(posedge wclk) disable iff (!arst_n)
    (w_rst_n && !cfg_sel && !wr_en_n && (!rd_en_n || !shift_en_n))
      |=> $stable({full_ofs, empty_ofs}));

  assert_dout_hold_R4: assert property (@(posedge rclk) disable iff (!arst_n)
    (r_rst_n && !(!cfg_sel && wr_en_n && !rd_en_n)) |=> $stable(dout));

  assert_cnt_range_R6: assert property (@(posedge wclk) disable iff (!arst_n)
    ser_cnt <= ($bits(ser_cnt))'(TOT_W - 1));
endmodule

bind ofs_loader ofs_loader_chk #(.OFS_W(OFS_W), .DATA_W(DATA_W)) chk_i (
  .wclk(wclk), .rclk(rclk), .arst_n(arst_n), .w_rst_n(w_rst_n), .r_rst_n(r_rst_n),
  .cfg_sel(cfg_sel), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .shift_en_n(shift_en_n),
  .dout(dout), .empty_ofs(empty_ofs), .full_ofs(full_ofs), .mem_wr(mem_wr), .mem_rd(mem_rd),
  .load_mode(load_mode), .ser_cnt(ser_cnt)
);

// File: tb/ofs_loader_tb_top.sv
`timescale 1ns/1ps
module ofs_loader_tb_top;
  localparam int OFS_W  = 18;
  localparam int DATA_W = 18;
  localparam int TOT_W  = 2 * OFS_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              arst_n = 1'b0;
  logic              cfg_sel = 1'b0;
  logic              wr_en_n = 1'b1;
  logic              rd_en_n = 1'b1;
  logic              shift_en_n = 1'b1;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic [OFS_W-1:0]  empty_ofs, full_ofs;
  logic              mem_wr, mem_rd;

  ofs_loader #(.OFS_W(OFS_W), .DATA_W(DATA_W)) dut_i (
    .wclk(clk), .rclk(clk), .arst_n(arst_n), .cfg_sel(cfg_sel), .wr_en_n(wr_en_n),
    .rd_en_n(rd_en_n), .shift_en_n(shift_en_n), .din(din), .dout(dout),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs), .mem_wr(mem_wr), .mem_rd(mem_rd)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model built from the requirements
  logic [DATA_W-1:0] m_reg [4];
  int                m_wptr, m_rptr, m_cnt;
  bit                m_ser;
  logic [DATA_W-1:0] exp_q [$];
  string             tag_q [$];
  logic [DATA_W-1:0] last_dout = '0;

  function automatic logic [TOT_W-1:0] model_flat();
    return {m_reg[3][1:0], m_reg[2][15:0], m_reg[1][1:0], m_reg[0][15:0]};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(bit s, bit w, bit r, bit sh, logic [DATA_W-1:0] d);
    @(negedge clk);
    #1;
    cfg_sel = s; wr_en_n = w; rd_en_n = r; shift_en_n = sh; din = d;
  endtask

  task automatic idle();
    drive(1'b0, 1'b1, 1'b1, 1'b1, '0);
  endtask

  task automatic do_reset(bit sel);
    @(negedge clk);
    #1;
    arst_n = 1'b0; cfg_sel = sel; wr_en_n = 1'b1; rd_en_n = 1'b1; shift_en_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 arst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 cfg_sel = 1'b0;
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    m_reg[0] = sel ? 18'h003FF : 18'h0007F;
    m_reg[2] = m_reg[0];
    m_wptr = 0; m_rptr = 0; m_cnt = 0; m_ser = sel;
    exp_q.delete(); tag_q.delete();
  endtask

  task automatic par_wr(logic [DATA_W-1:0] d);
    drive(1'b0, 1'b0, 1'b1, 1'b1, d);
    if (!m_ser) begin
      m_reg[m_wptr] = (m_wptr % 2 == 0) ? {2'b0, d[15:0]} : {16'b0, d[1:0]};
      m_wptr = (m_wptr + 1) % 4;
    end
  endtask

  task automatic par_rd(string tag);
    drive(1'b0, 1'b1, 1'b0, 1'b1, '0);
    exp_q.push_back(m_reg[m_rptr]);
    tag_q.push_back(tag);
    m_rptr = (m_rptr + 1) % 4;
  endtask

  task automatic shift(bit b);
    drive(1'b0, 1'b1, 1'b1, 1'b0, {17'b0, b});
    if (m_ser) begin
      int g = m_cnt / OFS_W;
      int j = m_cnt % OFS_W;
      if (j < 16) m_reg[2*g][j] = b;
      else        m_reg[2*g+1][j-16] = b;
      m_cnt = (m_cnt + 1) % TOT_W;
    end
  endtask

  task automatic shift_word(logic [TOT_W-1:0] v);
    for (int k = 0; k < TOT_W; k++) shift(v[k]);
  endtask

  task automatic check_ofs(string tag);
    idle();
    check(tag, {28'b0, full_ofs, empty_ofs}, {28'b0, model_flat()});
  endtask

  // monitor: scores each readback against the queued expectation
  always @(negedge clk) begin
    if (arst_n === 1'b1 && cfg_sel === 1'b0 && wr_en_n === 1'b1 && rd_en_n === 1'b0) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R4 unexpected read actual=%0h expected=none", dout);
      end else begin
        check(tag_q.pop_front(), 64'(dout), 64'(exp_q.pop_front()));
      end
      last_dout = dout;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1/R9: defaults with select low, pointers at empty low
    do_reset(1'b0);
    check_ofs("R1 defaults sel0");
    check("R4 dout after reset", 64'(dout), 64'h0);
    for (int i = 0; i < 5; i++) par_rd("R4 readback wrap");
    idle();

    // R3: write order, high-word truncation, wrap
    par_wr(18'h01234);
    par_wr(18'h3FFFF);
    par_wr(18'h00ABC);
    par_wr(18'h00002);
    check_ofs("R3 four-word write");
    check("R3 empty value", 64'(empty_ofs), 64'h31234);
    par_wr(18'h25555);
    check_ofs("R3 write pointer wrap");
    for (int i = 0; i < 4; i++) par_rd("R4 readback after write");
    idle();

    // R7: shift ignored in parallel method
    for (int i = 0; i < 6; i++) shift(1'b1);
    check_ofs("R7 shift ignored parallel");

    // R10: undefined combinations
    drive(1'b0, 1'b0, 1'b0, 1'b1, 18'h0FFFF);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 18'h0FFFF);
    check_ofs("R10 illegal combos");

    // R8: memory space strobes
    drive(1'b1, 1'b0, 1'b1, 1'b1, 18'h0BEEF);
    #1 check("R8 mem_wr", {62'b0, mem_wr, mem_rd}, 64'b10);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 18'h0BEEF);
    #1 check("R8 mem_rd", {62'b0, mem_wr, mem_rd}, 64'b01);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 18'h0BEEF);
    #1 check("R8 both strobes", {62'b0, mem_wr, mem_rd}, 64'b11);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 18'h0BEEF);
    #1 check("R8 no strobe", {62'b0, mem_wr, mem_rd}, 64'b00);
    idle();
    #1 check("R8 prog space strobes low", {62'b0, mem_wr, mem_rd}, 64'b00);
    check("R8 dout unchanged", 64'(dout), 64'(last_dout));
    check_ofs("R8 offsets unchanged");

    // R2: method locked; ld toggled, shift still ignored
    drive(1'b1, 1'b1, 1'b1, 1'b1, '0);
    for (int i = 0; i < 3; i++) shift(1'b0);
    check_ofs("R2 method locked parallel");

    // R1/R2/R5: serial method
    do_reset(1'b1);
    check_ofs("R1 defaults sel1");
    par_wr(18'h01111);
    check_ofs("R7 write ignored serial");
    shift_word({18'h1F00F, 18'h2A5C3});
    check_ofs("R5 serial load");
    check("R5 full value", 64'(full_ofs), 64'h1F00F);
    for (int i = 0; i < 4; i++) par_rd("R4 readback serial method");
    idle();

    // R6: restart at bit 0
    for (int i = 0; i < 5; i++) shift(1'b1);
    check_ofs("R6 restart after full count");
    check("R6 empty value", 64'(empty_ofs), 64'h2A5DF);

    // R9: reset mid-load clears counter
    for (int i = 0; i < 3; i++) shift(1'b0);
    do_reset(1'b1);
    shift_word({18'h30001, 18'h0F0F0});
    check_ofs("R9 counter cleared");

    // R2/R9: back to parallel, pointers cleared
    do_reset(1'b0);
    shift(1'b1);
    par_wr(18'h00042);
    check_ofs("R9 write pointer cleared");
    check("R9 empty value", 64'(empty_ofs), 64'h00042);
    par_rd("R9 read pointer cleared");
    idle();
    idle();
    check("R4 queue drained", 64'(exp_q.size()), 64'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule